// File: doc/BRIEF.md
# Converter Output Stage and Calibration Sequencer

This block is the digital back end of a pipelined 8-bit sampling converter. An abstracted core gives it one raw offset-binary code and one over-range flag per sample. The block delays each pair by a fixed 28-sample latency and converts the code to the selected output format. It then drives a parallel data bus, an over-range pin and a forwarded sample clock.

The block also sequences calibration. Calibration runs once after power-up and again each time the active-low recalibration request is released. A cycle counter of parameterised length stands in for the calibration engine. While calibration is busy, the over-range pin doubles as a busy flag. While the request is held low, or during the power-up calibration, the forwarded clock is frozen low.

The converter clock `ck_in` is not used as a clock. A faster system clock `clk` samples it, and the sample clock is derived from it either undivided or halved. All outputs are registers in the `clk` domain.

Top module: `adcb_backend`

## Requirements
- R1: A code captured on a rising edge of `clk_out` is on `dout` when the 28th following rising edge of `clk_out` occurs.
- R2: With `fmt_n` high, `dout` is the core code unchanged (offset binary). With `fmt_n` low, `dout` is the core code with bit 7 inverted (two's complement).
- R3: `ovr_out` outside calibration carries the `core_ovr` captured with the same sample, with the same 28-sample delay as the data.
- R4: While `por` is high, and for `CAL_CYCLES` `clk` cycles after it falls, `clk_out` and `dout` stay 0 and `ovr_out` stays 1.
- R5: From the first `clk` edge that sees `recal_n` low until it is released, `clk_out` is 0 with no edges. It resumes with the first rising edge of `ck_in` after release.
- R6: `ovr_out` is 1 from the `clk` edge that sees `recal_n` low until exactly `CAL_CYCLES` `clk` cycles after the edge that sees it high again.
- R7: Pulling `recal_n` low during a calibration abandons it. The count starts again from zero at the next release.
- R8: Samples held in the delay line when calibration starts are discarded. Samples captured during calibration are invalid. An invalid sample gives `dout` = 0 and a low over-range value.
- R9: With `div_n` low, `clk_out` toggles only on rising edges of `ck_in`. Its period is two `ck_in` periods and its duty cycle is 50%.
- R10: With `div_n` high, `clk_out` follows `ck_in` one `clk` cycle later.
- R11: `dout` changes only on the `clk` edge where `clk_out` falls, or when the clock is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the converter clock |
| por | input | 1 | Synchronous active-high power-on reset |
| recal_n | input | 1 | Active-low recalibration request |
| fmt_n | input | 1 | Output format: low selects two's complement, high selects offset binary |
| div_n | input | 1 | Clock divide: low halves the converter clock |
| ck_in | input | 1 | Converter input clock, sampled by `clk` |
| core_code | input | 8 | Offset-binary code from the core |
| core_ovr | input | 1 | Over-range flag from the core |
| dout | output | 8 | Formatted output data |
| ovr_out | output | 1 | Over-range output, high while calibration is busy |
| clk_out | output | 1 | Forwarded sample clock |

## Verification
Assertions check several rules on every cycle:
- the frozen clock stays low while the sequencer holds it;
- the over-range pin rises on the edge after a request;
- the data bus changes only at clock falls or while frozen;
- the data bus is zero while frozen;
- the calibration count sits at zero while held;
- the sample clock tracks `ck_in` in each divide mode.

The bench scenarios cover the rest. A cycle model shows the exact 28-sample latency and each output format. It also shows the over-range flag carried with its sample and the precise length of the busy window after an interrupted calibration. It measures the high and low run lengths of `clk_out` in both divide modes.

// File: rtl/adcb_pkg.sv
`timescale 1ns/1ps
package adcb_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        SQ_PWRUP = 2'd0,
        SQ_HOLD  = 2'd1,
        SQ_CAL   = 2'd2,
        SQ_RUN   = 2'd3
    } seq_e;

    typedef struct packed {
        logic              vld;
        logic              ovr;
        logic [CODE_W-1:0] code;
    } smp_t;

    function automatic logic [CODE_W-1:0] fmt_code(input logic [CODE_W-1:0] c,
                                                   input logic twos);
        return twos ? {~c[CODE_W-1], c[CODE_W-2:0]} : c;
    endfunction

endpackage

// File: rtl/adcb_cal_seq.sv
`timescale 1ns/1ps
module adcb_cal_seq
    import adcb_pkg::*;
#(
    parameter int CAL_CYCLES = 1000
) (
    input  logic clk,
    input  logic por,
    input  logic recal_n,
    output logic busy,
    output logic stopped,
    output logic run_nxt,
    output logic cap_ok
);
    localparam int CW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

    seq_e           st, nx;
    logic [CW-1:0]  cnt;
    logic           done;

    assign done = (cnt == LAST);

    always_comb begin
        nx = st;
        unique case (st)
            SQ_PWRUP: if (!recal_n) nx = SQ_HOLD; else if (done) nx = SQ_RUN;
            SQ_HOLD:  if (recal_n)  nx = SQ_CAL;
            SQ_CAL:   if (!recal_n) nx = SQ_HOLD; else if (done) nx = SQ_RUN;
            SQ_RUN:   if (!recal_n) nx = SQ_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            st  <= SQ_PWRUP;
            cnt <= '0;
        end else begin
            st <= nx;
            if (nx != st)
                cnt <= '0;
            else if (st == SQ_PWRUP || st == SQ_CAL)
                cnt <= cnt + 1'b1;
        end
    end

    assign busy    = (st != SQ_RUN);
    assign stopped = (st == SQ_PWRUP) || (st == SQ_HOLD);
    assign run_nxt = (nx == SQ_CAL) || (nx == SQ_RUN);
    assign cap_ok  = (nx == SQ_RUN);

    // R7
    restart_cnt_chk: assert property (@(posedge clk) disable iff (por)
        (st == SQ_HOLD) |=> (cnt == '0));

endmodule

// File: rtl/adcb_clk_gen.sv
`timescale 1ns/1ps
module adcb_clk_gen (
    input  logic clk,
    input  logic por,
    input  logic ck_in,
    input  logic div_n,
    input  logic run_nxt,
    output logic sclk,
    output logic se,
    output logic sf
);
    logic ck_q, ck_rise, sclk_nx;

    assign ck_rise = ck_in & ~ck_q;

    always_comb begin
        if (!run_nxt)
            sclk_nx = 1'b0;
        else if (div_n)
            sclk_nx = ck_in;
        else if (ck_rise)
            sclk_nx = ~sclk;
        else
            sclk_nx = sclk;
    end

    assign se = sclk_nx & ~sclk;
    assign sf = ~sclk_nx & sclk;

    always_ff @(posedge clk) begin
        if (por) begin
            ck_q <= 1'b0;
            sclk <= 1'b0;
        end else begin
            ck_q <= ck_in;
            sclk <= sclk_nx;
        end
    end

    // R10
    follow_chk: assert property (@(posedge clk) disable iff (por)
        ($past(div_n) && $past(run_nxt)) |-> (sclk == $past(ck_in)));

    // R9
    div_toggle_chk: assert property (@(posedge clk) disable iff (por)
        (!$past(div_n) && $past(run_nxt) && !$stable(sclk)) |-> ($past(ck_in) && !$past(ck_q)));

endmodule

// File: rtl/adcb_delay_line.sv
`timescale 1ns/1ps
module adcb_delay_line
    import adcb_pkg::*;
#(
    parameter int DEPTH = 28
) (
    input  logic clk,
    input  logic por,
    input  logic flush,
    input  logic adv,
    input  smp_t din,
    output smp_t dout
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        smp_t src;
        smp_t q;
        if (i == 0) begin : g_head
            assign src = din;
        end else begin : g_body
            assign src = g_stg[i-1].q;
        end
        always_ff @(posedge clk) begin
            if (por || flush)
                q <= '0;
            else if (adv)
                q <= src;
        end
    end

    assign dout = g_stg[DEPTH-1].q;

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (por)
        flush |=> (dout.vld == 1'b0));

endmodule

// File: rtl/adcb_out_fmt.sv
`timescale 1ns/1ps
module adcb_out_fmt
    import adcb_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              clear,
    input  logic              load,
    input  logic              twos,
    input  smp_t              smp,
    output logic [CODE_W-1:0] dout,
    output logic              ovr
);
    always_ff @(posedge clk) begin
        if (por || clear) begin
            dout <= '0;
            ovr  <= 1'b0;
        end else if (load) begin
            dout <= smp.vld ? fmt_code(smp.code, twos) : '0;
            ovr  <= smp.vld & smp.ovr;
        end
    end
endmodule

// File: rtl/adcb_backend.sv
`timescale 1ns/1ps
module adcb_backend
    import adcb_pkg::*;
#(
    parameter int LATENCY    = 28,
    parameter int CAL_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              por,
    input  logic              recal_n,
    input  logic              fmt_n,
    input  logic              div_n,
    input  logic              ck_in,
    input  logic [CODE_W-1:0] core_code,
    input  logic              core_ovr,
    output logic [CODE_W-1:0] dout,
    output logic              ovr_out,
    output logic              clk_out
);
    logic busy, stopped, run_nxt, cap_ok;
    logic sclk, se, sf, ovr_q;
    smp_t din, tail;

    adcb_cal_seq #(.CAL_CYCLES(CAL_CYCLES)) u_seq (
        .clk(clk), .por(por), .recal_n(recal_n),
        .busy(busy), .stopped(stopped), .run_nxt(run_nxt), .cap_ok(cap_ok)
    );

    adcb_clk_gen u_ck (
        .clk(clk), .por(por), .ck_in(ck_in), .div_n(div_n), .run_nxt(run_nxt),
        .sclk(sclk), .se(se), .sf(sf)
    );

    assign din = '{vld: cap_ok, ovr: core_ovr, code: core_code};

    adcb_delay_line #(.DEPTH(LATENCY)) u_dly (
        .clk(clk), .por(por), .flush(!run_nxt), .adv(se), .din(din), .dout(tail)
    );

    adcb_out_fmt u_fmt (
        .clk(clk), .por(por), .clear(!run_nxt), .load(sf), .twos(!fmt_n),
        .smp(tail), .dout(dout), .ovr(ovr_q)
    );

    assign clk_out = sclk;
    assign ovr_out = busy | ovr_q;

    // R5
    stop_low_chk: assert property (@(posedge clk) disable iff (por)
        stopped |-> !clk_out);

    // R6
    ovr_on_req_chk: assert property (@(posedge clk) disable iff (por)
        !recal_n |=> ovr_out);

    // R11
    out_edge_chk: assert property (@(posedge clk) disable iff (por)
        !$stable(dout) |-> ($fell(clk_out) || stopped));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (por)
        stopped |-> (dout == '0));

endmodule

// File: tb/adcb_backend_bench.sv
`timescale 1ns/1ps
module adcb_backend_bench;
    localparam int LAT = 28;
    localparam int CAL = 60;

    logic       clk = 1'b0;
    logic       por, recal_n, fmt_n, div_n, ck_in, core_ovr;
    logic [7:0] core_code;
    logic [7:0] dout;
    logic       ovr_out, clk_out;

    always #2.5 clk = ~clk;

    adcb_backend #(.LATENCY(LAT), .CAL_CYCLES(CAL)) u_adcb_backend (
        .clk(clk), .por(por), .recal_n(recal_n), .fmt_n(fmt_n), .div_n(div_n),
        .ck_in(ck_in), .core_code(core_code), .core_ovr(core_ovr),
        .dout(dout), .ovr_out(ovr_out), .clk_out(clk_out)
    );

    int tests = 0, fails = 0;
    int rem = 0, run_len = 0, last_hi = 0, last_lo = 0, ph = 0, idx = 0;
    bit held = 0, pwr = 0, stop = 0, busy = 0, was_busy = 0, done = 0;
    logic prev_clk = 1'b0;
    logic [7:0] prev_dout = 8'h00;
    logic [9:0] hist[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [9:0] e;
        logic [7:0] expd;
        logic       expo;
        @(negedge clk);
        if (por) begin rem = CAL; pwr = 1; held = 0; end
        else if (!recal_n) begin rem = CAL; held = 1; pwr = 0; end
        else if (held) held = 0;
        else if (rem > 0) begin rem--; if (rem == 0) pwr = 0; end
        was_busy = busy;
        busy = held || (rem > 0);
        stop = held || pwr;

        if (stop) begin
            chk(clk_out == 1'b0, "R5 clock frozen low", clk_out, 0);
            if (pwr) chk(dout == 8'h00, "R4 data zero in power-up", dout, 0);
            hist.delete();
        end
        if (busy) chk(ovr_out == 1'b1, "R6 busy on over-range pin", ovr_out, 1);
        if (was_busy && !busy)
            chk(ovr_out == 1'b0 && dout == 8'h00, "R8 output invalid after calibration",
                {ovr_out, dout}, 0);
        if (!stop && dout !== prev_dout)
            chk(prev_clk == 1'b1 && clk_out == 1'b0, "R11 data change at clock fall",
                clk_out, 0);

        if (clk_out !== prev_clk) begin
            if (prev_clk) last_hi = run_len; else last_lo = run_len;
            run_len = 1;
        end else run_len++;

        if (clk_out && !prev_clk && !stop) begin
            hist.push_back({~busy, core_ovr, core_code});
            if (hist.size() > LAT) begin
                e = hist.pop_front();
                expd = e[9] ? (fmt_n ? e[7:0] : {~e[7], e[6:0]}) : 8'h00;
                expo = busy | (e[9] & e[8]);
            end else begin
                expd = 8'h00;
                expo = busy;
            end
            chk(dout == expd, fmt_n ? "R1 R2 offset-binary data" : "R1 R2 two's-complement data",
                dout, expd);
            chk(ovr_out == expo, "R3 over-range alignment", ovr_out, expo);
            idx++;
            case (idx % 50)
                0: core_code = 8'h00;
                1: core_code = 8'hFF;
                2: core_code = 8'h7F;
                3: core_code = 8'h80;
                default: core_code = 8'((idx * 73 + 11) & 255);
            endcase
            core_ovr = (idx % 7 == 0);
        end
        prev_clk  = clk_out;
        prev_dout = dout;
        ck_in = (ph == 0);
        ph = (ph + 1) % 4;
    endtask

    initial begin
        int n;
        por = 1; recal_n = 1; fmt_n = 1; div_n = 1; ck_in = 0;
        core_code = 8'h00; core_ovr = 0;
        repeat (3) step();
        // R4 reset state
        chk(clk_out == 0, "R4 reset clk_out", clk_out, 0);
        chk(ovr_out == 1, "R4 reset ovr_out", ovr_out, 1);
        chk(dout == 0, "R4 reset dout", dout, 0);
        por = 0;
        repeat (CAL + 200) step();
        chk(last_hi == 1 && last_lo == 3, "R10 undivided follows input",
            last_hi * 16 + last_lo, 16 + 3);

        recal_n = 0;
        repeat (3) step();
        fmt_n = 0;
        recal_n = 1;
        repeat (CAL + 200) step();

        recal_n = 0;
        step();
        div_n = 0;
        recal_n = 1;
        repeat (CAL + 500) step();
        chk(last_hi == 4 && last_lo == 4, "R9 divided clock duty",
            last_hi * 16 + last_lo, 4 * 16 + 4);

        recal_n = 0; step();
        recal_n = 1; repeat (20) step();
        recal_n = 0; step();
        recal_n = 1;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            step();
            if (ovr_out) n++; else break;
        end
        chk(n == CAL, "R7 restarted calibration length", n, CAL);
        repeat (400) step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule